// File: doc/BRIEF.md
# I2C Master Command and Byte FIFO Engine

This block is the host-facing half of an I2C master. The host writes a command word that names a 7-bit target, a direction, a byte count and whether the transfer opens with a start condition and closes with a stop condition. The block screens the command, loads two residual byte counters with the count, and then moves bytes between an 8-entry byte FIFO, host accesses to the FIFO port, and an abstract byte-level bus engine. One residual counts bytes still to move on the bus side, the other counts host FIFO accesses still expected.

The bus engine is driven by a request/operation handshake: the block raises `bus_req_o` with an operation code and holds it until the engine returns a one-cycle `bus_done_i`, together with an ack/nack flag and, for a receive, a data byte. Only one bus operation is outstanding at a time. Errors are sticky flags that only reset clears. A pacing input turns FIFO overrun into a silent drop.

Top module: `i2cm_cmd_engine`

## Requirements
- R1: After reset `cmd_done_o` is 1; `xfer_busy_o`, all four error flags, `fifo_level_o`, both residual outputs, `host_rdata_o` and `bus_req_o` are 0.
- R2: The command word has the length in bits 15:0, read-not-write in bit 16, the target address in bits 23:17, start in bit 24, address-phase in bit 25, read-continue in bit 26 and stop in bit 27. A command with start, address-phase and stop all clear and a length of zero sets `err_bad_cmd_o` and issues no bus operation.
- R3: A command written while `cmd_done_o` is 0, or while a bus operation is outstanding, sets `err_bad_cmd_o` and leaves both residuals unchanged.
- R4: An accepted command loads both residuals with its length on the next cycle; if its start bit is set, a START operation (`bus_op_o` = 0) is requested carrying the command's address and direction. Operation codes: 0 start, 1 send, 2 receive, 3 stop.
- R5: A nack on START sets `err_nack_o`, leaves `xfer_busy_o` at 0 and `cmd_done_o` at 1, and issues no further operation; an ack sets `xfer_busy_o`.
- R6: In a write transfer every byte the host writes is sent by a SEND operation (code 1) in FIFO order, one operation at a time, and each completed send decrements the bus-side residual.
- R7: In a read transfer each completed RECV (code 2) pushes the engine's byte into the FIFO and decrements the bus-side residual; host reads return those bytes in order on `host_rdata_o` one cycle after the read strobe, each decrementing the host-side residual.
- R8: A host write during a read transfer, a host read during a write transfer, or either access while `xfer_busy_o` is 0 sets `err_bad_cmd_o` and leaves the FIFO level unchanged.
- R9: A host write to a full FIFO, or a host read from an empty FIFO, is dropped and sets `err_overrun_o`, unless `pace_allow_i` is 1, in which case it is dropped with no error.
- R10: A host access made when the host-side residual is already 0 sets `err_host_len_o` and leaves that residual at 0.
- R11: A nack on a SEND sets `err_nack_o`, issues a STOP (code 3), then clears `xfer_busy_o` and sets `cmd_done_o`.
- R12: When both residuals reach zero, `cmd_done_o` is set; if the command had its stop bit, a STOP is issued and `xfer_busy_o` clears after it; otherwise `xfer_busy_o` stays 1.
- R13: `fifo_level_o` reports the number of FIFO entries, from 0 up to 8, and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_word_i | input | 28 | Command word |
| pace_allow_i | input | 1 | Drop FIFO overrun accesses without error |
| host_wr_i | input | 1 | Host FIFO write strobe |
| host_wdata_i | input | 8 | Host FIFO write byte |
| host_rd_i | input | 1 | Host FIFO read strobe |
| host_rdata_o | output | 8 | Last byte read by the host |
| cmd_done_o | output | 1 | Command complete |
| xfer_busy_o | output | 1 | Transfer in progress on the bus |
| err_bad_cmd_o | output | 1 | Sticky invalid command or access |
| err_nack_o | output | 1 | Sticky nack received |
| err_overrun_o | output | 1 | Sticky FIFO overrun |
| err_host_len_o | output | 1 | Sticky host access beyond length |
| fifo_level_o | output | 8 | FIFO fill count |
| bus_left_o | output | 16 | Bus-side residual byte count |
| host_left_o | output | 16 | Host-side residual byte count |
| bus_req_o | output | 1 | Bus operation request |
| bus_op_o | output | 2 | Bus operation code |
| bus_addr_o | output | 7 | Target address for START |
| bus_rnw_o | output | 1 | Direction for START |
| bus_wdata_o | output | 8 | Byte for SEND |
| bus_done_i | input | 1 | Bus operation complete pulse |
| bus_nack_i | input | 1 | Nack flag, valid with done |
| bus_rdata_i | input | 8 | Received byte, valid with done of RECV |

## Verification
The host FIFO port and the bus sequencer can touch the FIFO and the residuals in the same cycle: a host read can pop while a completed receive pushes, and a host write can push while a send launch pops. The bench provokes this by issuing host reads as soon as the level is non-zero while the bus model keeps completing receives, and host writes back to back while sends drain, across lengths 1 to 8 in both directions. It judges the result by the exact byte order on both sides, the final residuals, the operation log ending in a single STOP, and the absence of any error flag.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C master command engine.
// Assumes: command word fields are packed MSB-first as declared in cmd_t.
package i2cm_pkg;
    localparam int LEN_W  = 16;
    localparam int DEV_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_SEND  = 2'd1,
        BUS_RECV  = 2'd2,
        BUS_STOP  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic             stop;
        logic             rdcont;
        logic             with_addr;
        logic             start;
        logic [DEV_W-1:0] dev;
        logic             rnw;
        logic [LEN_W-1:0] len;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_XFER, ST_SEND, ST_RECV, ST_STOP
    } seq_st_e;
endpackage

// File: rtl/i2cm_byte_fifo.sv
// Circular byte FIFO with a fill counter.
// Assumes: the caller never pushes when full unless it pops in the same
// cycle, and never pops when empty. Head data is read combinationally.
module i2cm_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= din_i;
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_i) wr_ptr <= step(wr_ptr);
            if (pop_i)  rd_ptr <= step(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = cnt;
    assign full_o  = (cnt == CAP);
    assign empty_o = (cnt == '0);

    a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> (cnt < CAP));
    a_r13_level_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);
endmodule

// File: rtl/i2cm_host_port.sv
// Host-side FIFO access screening.
// Classifies each host read or write as wrong-direction/idle (invalid),
// overrun (dropped) or accepted, and flags accesses past the expected
// length. Holds the last popped byte for the host.
// Assumes: busy_i and rnw_i describe the transfer currently in progress.
module i2cm_host_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic         busy_i,
    input  logic         rnw_i,
    input  logic         pace_i,
    input  logic         full_i,
    input  logic         empty_i,
    input  logic         be_zero_i,
    input  logic [W-1:0] head_i,
    output logic         push_o,
    output logic         pop_o,
    output logic         be_dec_o,
    output logic         err_inv_o,
    output logic         err_ovr_o,
    output logic         err_acc_o,
    output logic [W-1:0] rdata_o
);
    logic bad_wr, bad_rd, ok_wr, ok_rd, moved;

    // Access classification.
    always_comb begin
        bad_wr    = wr_i && (!busy_i || rnw_i);
        bad_rd    = rd_i && (!busy_i || !rnw_i);
        ok_wr     = wr_i && !bad_wr;
        ok_rd     = rd_i && !bad_rd;
        push_o    = ok_wr && !full_i;
        pop_o     = ok_rd && !empty_i;
        moved     = push_o || pop_o;
        err_inv_o = bad_wr || bad_rd;
        err_ovr_o = ((ok_wr && full_i) || (ok_rd && empty_i)) && !pace_i;
        err_acc_o = moved && be_zero_i;
        be_dec_o  = moved && !be_zero_i;
    end

    // Read-data register, loaded on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_o <= '0;
        else if (pop_o) rdata_o <= head_i;
    end

    a_r9_overrun_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr_o |-> !(push_o || pop_o));
    a_r8_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_i || rd_i) && !busy_i) |-> !(push_o || pop_o));
endmodule

// File: rtl/i2cm_bus_seq.sv
// Command acceptance and bus-side sequencer.
// Screens commands, owns both residual counters, the busy and complete
// flags and the sticky errors, and drives one bus operation at a time,
// holding the request until the engine's done pulse.
// Assumes: bus_done_i is a single-cycle pulse only while bus_req_o is high.
module i2cm_bus_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  cmd_t              cmd_i,
    input  logic              host_be_dec_i,
    input  logic              host_inv_i,
    input  logic              host_ovr_i,
    input  logic              host_acc_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_full_i,
    input  logic [BYTE_W-1:0] fifo_head_i,
    output logic              seq_pop_o,
    output logic              seq_push_o,
    output logic              bus_req_o,
    output logic [1:0]        bus_op_o,
    output logic [DEV_W-1:0]  bus_addr_o,
    output logic              bus_rnw_o,
    output logic [BYTE_W-1:0] bus_wdata_o,
    input  logic              bus_done_i,
    input  logic              bus_nack_i,
    output logic              busy_o,
    output logic              rnw_o,
    output logic              done_o,
    output logic              e_inv_o,
    output logic              e_nack_o,
    output logic              e_ovr_o,
    output logic              e_acc_o,
    output logic [LEN_W-1:0]  fe_o,
    output logic [LEN_W-1:0]  be_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seq_st_e           state_q;
    logic [LEN_W-1:0]  fe_q, be_q;
    logic [DEV_W-1:0]  addr_q;
    logic [BYTE_W-1:0] wdata_q;
    logic              rnw_q, stop_q, busy_q, done_q;
    logic              cmd_nil, accept, reject, all_zero;
    logic              launch_send, launch_recv;
    logic              unused_rdcont;

    assign unused_rdcont = cmd_i.rdcont;

    // Command screening and data-launch decisions.
    always_comb begin
        cmd_nil     = !(cmd_i.start || cmd_i.with_addr || cmd_i.stop) &&
                      (cmd_i.len == '0);
        accept      = cmd_wr_i && !cmd_nil && done_q && (state_q == ST_IDLE);
        reject      = cmd_wr_i && !accept;
        all_zero    = (fe_q == '0) && (be_q == '0);
        launch_send = (state_q == ST_XFER) && !all_zero && !rnw_q &&
                      (fe_q != '0) && !fifo_empty_i;
        launch_recv = (state_q == ST_XFER) && !all_zero && rnw_q &&
                      (fe_q != '0) && !fifo_full_i;
    end

    // Bus request and operation code from the sequencer state.
    always_comb begin
        bus_req_o = 1'b1;
        bus_op_o  = BUS_START;
        case (state_q)
            ST_START: bus_op_o = BUS_START;
            ST_SEND:  bus_op_o = BUS_SEND;
            ST_RECV:  bus_op_o = BUS_RECV;
            ST_STOP:  bus_op_o = BUS_STOP;
            default:  bus_req_o = 1'b0;
        endcase
    end

    // Sequencer state, residuals, flags and sticky errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fe_q     <= '0;
            be_q     <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rnw_q    <= 1'b0;
            stop_q   <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            e_inv_o  <= 1'b0;
            e_nack_o <= 1'b0;
            e_ovr_o  <= 1'b0;
            e_acc_o  <= 1'b0;
        end else begin
            if (reject || host_inv_i) e_inv_o <= 1'b1;
            if (host_ovr_i)           e_ovr_o <= 1'b1;
            if (host_acc_i)           e_acc_o <= 1'b1;
            if (host_be_dec_i)        be_q    <= be_q - ONE;
            case (state_q)
                ST_IDLE: if (accept) begin
                    fe_q   <= cmd_i.len;
                    be_q   <= cmd_i.len;
                    addr_q <= cmd_i.dev;
                    rnw_q  <= cmd_i.rnw;
                    stop_q <= cmd_i.stop;
                    if (cmd_i.start) begin
                        state_q <= ST_START;
                        done_q  <= 1'b0;
                    end else if (busy_q) begin
                        state_q <= ST_XFER;
                        done_q  <= 1'b0;
                    end
                end
                ST_START: if (bus_done_i) begin
                    if (bus_nack_i) begin
                        e_nack_o <= 1'b1;
                        busy_q   <= 1'b0;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        busy_q  <= 1'b1;
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (all_zero) begin
                        done_q  <= 1'b1;
                        state_q <= stop_q ? ST_STOP : ST_IDLE;
                    end else if (launch_send) begin
                        wdata_q <= fifo_head_i;
                        state_q <= ST_SEND;
                    end else if (launch_recv) begin
                        state_q <= ST_RECV;
                    end
                end
                ST_SEND: if (bus_done_i) begin
                    fe_q <= fe_q - ONE;
                    if (bus_nack_i) begin
                        e_nack_o <= 1'b1;
                        state_q  <= ST_STOP;
                    end else begin
                        state_q <= ST_XFER;
                    end
                end
                ST_RECV: if (bus_done_i) begin
                    fe_q    <= fe_q - ONE;
                    state_q <= ST_XFER;
                end
                ST_STOP: if (bus_done_i) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign seq_pop_o   = launch_send;
    assign seq_push_o  = (state_q == ST_RECV) && bus_done_i;
    assign bus_addr_o  = addr_q;
    assign bus_rnw_o   = rnw_q;
    assign bus_wdata_o = wdata_q;
    assign busy_o      = busy_q;
    assign rnw_o       = rnw_q;
    assign done_o      = done_q;
    assign fe_o        = fe_q;
    assign be_o        = be_q;

    a_r6_one_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_done_i) |=> (bus_req_o && $stable(bus_op_o)));
    a_r4_length_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && done_q && state_q == ST_IDLE && !cmd_nil) |=>
        (fe_q == $past(cmd_i.len)));
    a_r5_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ($past(state_q) == ST_START && $past(bus_done_i) &&
                           !$past(bus_nack_i)));
    a_r12_done_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && $past(state_q) == ST_XFER) |->
        (fe_q == '0 && be_q == '0));
endmodule

// File: rtl/i2cm_cmd_engine.sv
// I2C master command and FIFO engine, top level.
// Joins the byte FIFO, the host access port and the bus sequencer; the
// FIFO is fed by the host in write transfers and by the bus in reads.
// Assumes: host read and write strobes are single-cycle and not combined.
module i2cm_cmd_engine
    import i2cm_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [CMD_W-1:0]  cmd_word_i,
    input  logic              pace_allow_i,
    input  logic              host_wr_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    input  logic              host_rd_i,
    output logic [BYTE_W-1:0] host_rdata_o,
    output logic              cmd_done_o,
    output logic              xfer_busy_o,
    output logic              err_bad_cmd_o,
    output logic              err_nack_o,
    output logic              err_overrun_o,
    output logic              err_host_len_o,
    output logic [CNT_W-1:0]  fifo_level_o,
    output logic [LEN_W-1:0]  bus_left_o,
    output logic [LEN_W-1:0]  host_left_o,
    output logic              bus_req_o,
    output logic [1:0]        bus_op_o,
    output logic [DEV_W-1:0]  bus_addr_o,
    output logic              bus_rnw_o,
    output logic [BYTE_W-1:0] bus_wdata_o,
    input  logic              bus_done_i,
    input  logic              bus_nack_i,
    input  logic [BYTE_W-1:0] bus_rdata_i
);
    logic              f_push, f_pop, f_full, f_empty;
    logic [BYTE_W-1:0] f_din, f_head;
    logic              h_push, h_pop, h_dec, h_inv, h_ovr, h_acc;
    logic              s_push, s_pop, busy, rnw;
    logic [LEN_W-1:0]  be_left;

    // FIFO source selection: bus bytes in reads, host bytes in writes.
    assign f_push = h_push || s_push;
    assign f_pop  = h_pop  || s_pop;
    assign f_din  = rnw ? bus_rdata_i : host_wdata_i;

    i2cm_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(f_push), .din_i(f_din), .pop_i(f_pop),
        .head_o(f_head), .count_o(fifo_level_o),
        .full_o(f_full), .empty_o(f_empty)
    );

    i2cm_host_port #(.W(BYTE_W)) u_host (
        .clk(clk), .rst_n(rst_n),
        .wr_i(host_wr_i), .rd_i(host_rd_i),
        .busy_i(busy), .rnw_i(rnw), .pace_i(pace_allow_i),
        .full_i(f_full), .empty_i(f_empty), .be_zero_i(be_left == '0),
        .head_i(f_head),
        .push_o(h_push), .pop_o(h_pop), .be_dec_o(h_dec),
        .err_inv_o(h_inv), .err_ovr_o(h_ovr), .err_acc_o(h_acc),
        .rdata_o(host_rdata_o)
    );

    i2cm_bus_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_t'(cmd_word_i)),
        .host_be_dec_i(h_dec), .host_inv_i(h_inv),
        .host_ovr_i(h_ovr), .host_acc_i(h_acc),
        .fifo_empty_i(f_empty), .fifo_full_i(f_full), .fifo_head_i(f_head),
        .seq_pop_o(s_pop), .seq_push_o(s_push),
        .bus_req_o(bus_req_o), .bus_op_o(bus_op_o),
        .bus_addr_o(bus_addr_o), .bus_rnw_o(bus_rnw_o),
        .bus_wdata_o(bus_wdata_o),
        .bus_done_i(bus_done_i), .bus_nack_i(bus_nack_i),
        .busy_o(busy), .rnw_o(rnw), .done_o(cmd_done_o),
        .e_inv_o(err_bad_cmd_o), .e_nack_o(err_nack_o),
        .e_ovr_o(err_overrun_o), .e_acc_o(err_host_len_o),
        .fe_o(bus_left_o), .be_o(be_left)
    );

    assign xfer_busy_o = busy;
    assign host_left_o = be_left;
endmodule

// File: tb/i2cm_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module i2cm_cmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [27:0] cmd_word = '0;
    logic        pace = 1'b0;
    logic        hwr = 1'b0, hrd = 1'b0;
    logic [7:0]  hwdata = '0;
    logic [7:0]  hrdata;
    logic        done, busy, e_inv, e_nack, e_ovr, e_acc;
    logic [7:0]  level;
    logic [15:0] fe, be;
    logic        bus_req, bus_rnw;
    logic [1:0]  bus_op;
    logic [6:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_done, bus_nack;
    logic [7:0]  bus_rdata;

    int checks = 0, errors = 0;
    int log_n = 0, recv_idx = 0, wcnt = 0;
    logic [1:0] log_op [64];
    logic [7:0] log_dat [64];
    bit hold_bus = 0, nack_start = 0, nack_send = 0;

    always #10 clk = ~clk;

    i2cm_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_word_i(cmd_word),
        .pace_allow_i(pace), .host_wr_i(hwr), .host_wdata_i(hwdata),
        .host_rd_i(hrd), .host_rdata_o(hrdata), .cmd_done_o(done),
        .xfer_busy_o(busy), .err_bad_cmd_o(e_inv), .err_nack_o(e_nack),
        .err_overrun_o(e_ovr), .err_host_len_o(e_acc), .fifo_level_o(level),
        .bus_left_o(fe), .host_left_o(be), .bus_req_o(bus_req),
        .bus_op_o(bus_op), .bus_addr_o(bus_addr), .bus_rnw_o(bus_rnw),
        .bus_wdata_o(bus_wdata), .bus_done_i(bus_done), .bus_nack_i(bus_nack),
        .bus_rdata_i(bus_rdata)
    );

    // Bus engine model: completes each operation two cycles after request.
    initial begin
        bus_done = 0; bus_nack = 0; bus_rdata = 0;
        forever begin
            @(negedge clk);
            bus_done = 0; bus_nack = 0;
            if (bus_req && !hold_bus) begin
                wcnt++;
                if (wcnt >= 2) begin
                    wcnt = 0;
                    bus_done = 1;
                    if (log_n < 64) begin
                        log_op[log_n]  = bus_op;
                        log_dat[log_n] = (bus_op == 2'd0) ? {bus_rnw, bus_addr} : bus_wdata;
                        log_n++;
                    end
                    case (bus_op)
                        2'd0: bus_nack = nack_start;
                        2'd1: bus_nack = nack_send;
                        2'd2: begin bus_rdata = 8'hA0 + 8'(recv_idx); recv_idx++; end
                        default: ;
                    endcase
                end
            end else wcnt = 0;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; cmd_wr = 0; hwr = 0; hrd = 0; pace = 0;
        hold_bus = 0; nack_start = 0; nack_send = 0;
        tick(2);
        log_n = 0; recv_idx = 0;
        rst_n = 1;
        tick(1);
    endtask

    function automatic logic [27:0] mk(bit st, bit sp, bit rw, logic [6:0] dv, logic [15:0] ln);
        return {sp, 1'b0, st, st, dv, rw, ln};
    endfunction

    task automatic send_cmd(input logic [27:0] w);
        cmd_word = w; cmd_wr = 1; tick(1); cmd_wr = 0;
    endtask

    task automatic hwrite(input logic [7:0] b);
        hwdata = b; hwr = 1; tick(1); hwr = 0;
    endtask

    task automatic hread(output logic [7:0] b);
        hrd = 1; tick(1); hrd = 0; b = hrdata;
    endtask

    task automatic wait_busy(input bit v);
        for (int k = 0; k < 500; k++) begin
            if (busy == v) break;
            tick(1);
        end
    endtask

    logic [7:0] rb;

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 done", done, 1); chk("R1 busy", busy, 0);
        chk("R1 errors", {e_inv, e_nack, e_ovr, e_acc}, 0);
        chk("R1 level", level, 0); chk("R1 residuals", {fe, be}, 0);
        chk("R1 rdata", hrdata, 0); chk("R1 bus_req", bus_req, 0);

        // R2 all-zero command rejected
        send_cmd(28'h0);
        chk("R2 invalid", e_inv, 1);
        tick(5);
        chk("R2 no bus op", log_n, 0); chk("R2 bus_req", bus_req, 0);

        // R8 host access with no transfer
        do_reset();
        hwrite(8'h55);
        chk("R8 idle write invalid", e_inv, 1); chk("R8 idle level", level, 0);

        // Write sweep: R4 R6 R12
        for (int L = 1; L <= 8; L++) begin
            do_reset();
            send_cmd(mk(1, 1, 0, 7'(7'h20 + L), 16'(L)));
            chk("R4 bus residual", fe, L); chk("R4 host residual", be, L);
            chk("R4 start req", {bus_req, bus_op}, 3'b100);
            wait_busy(1);
            chk("R5 busy after ack", busy, 1);
            chk("R4 start addr", log_dat[0], {1'b0, 7'(7'h20 + L)});
            for (int i = 0; i < L; i++) hwrite({4'(L), 4'(i)});
            wait_busy(0);
            tick(2);
            chk("R12 done", done, 1);
            chk("R6 no errors", {e_inv, e_nack, e_ovr, e_acc}, 0);
            chk("R6 op count", log_n, L + 2);
            for (int i = 0; i < L; i++) begin
                chk("R6 send op", log_op[i + 1], 1);
                chk("R6 send data", log_dat[i + 1], {4'(L), 4'(i)});
            end
            chk("R12 stop last", log_op[L + 1], 3);
            chk("R6 residuals zero", {fe, be}, 0);
        end

        // Read sweep: R7 R12, host reads overlap bus receives
        for (int L = 1; L <= 8; L++) begin
            do_reset();
            send_cmd(mk(1, 1, 1, 7'h31, 16'(L)));
            wait_busy(1);
            chk("R4 start rnw", log_dat[0], {1'b1, 7'h31});
            for (int i = 0; i < L; i++) begin
                for (int k = 0; k < 100; k++) begin
                    if (level != 0) break;
                    tick(1);
                end
                hread(rb);
                chk("R7 read data", rb, 8'hA0 + 8'(i));
                chk("R7 host residual", be, L - 1 - i);
            end
            wait_busy(0);
            tick(2);
            chk("R7 no errors", {e_inv, e_nack, e_ovr, e_acc}, 0);
            chk("R7 op count", log_n, L + 2);
            chk("R12 read stop", log_op[L + 1], 3);
            chk("R12 read done", done, 1);
        end

        // Full FIFO with stalled bus: R13 R9 R3 R8
        for (int p = 0; p < 2; p++) begin
            do_reset();
            pace = 1'(p);
            send_cmd(mk(1, 1, 0, 7'h12, 16'd16));
            wait_busy(1);
            hold_bus = 1;
            hwrite(8'h01);
            tick(2);
            for (int i = 0; i < 8; i++) hwrite(8'(8'h10 + i));
            chk("R13 level full", level, 8);
            chk("R9 host residual", be, 7);
            send_cmd(mk(0, 0, 0, 7'h12, 16'd5));
            chk("R3 busy command invalid", e_inv, 1);
            chk("R3 residual kept", fe, 16);
            hwrite(8'hEE);
            chk("R9 overrun flag", e_ovr, p ? 0 : 1);
            chk("R9 write dropped", level, 8);
            chk("R9 residual unchanged", be, 7);
            hread(rb);
            chk("R8 wrong dir level", level, 8);
        end

        // Empty FIFO read with stalled bus: R9
        for (int p = 0; p < 2; p++) begin
            do_reset();
            pace = 1'(p);
            send_cmd(mk(1, 1, 1, 7'h44, 16'd2));
            wait_busy(1);
            hold_bus = 1;
            tick(2);
            hread(rb);
            chk("R9 empty overrun", e_ovr, p ? 0 : 1);
            chk("R9 empty level", level, 0);
            chk("R9 empty residual", be, 2);
            chk("R8 legal read not invalid", e_inv, 0);
        end

        // R10 and R12 without stop
        do_reset();
        send_cmd(mk(1, 0, 0, 7'h0A, 16'd1));
        wait_busy(1);
        hwrite(8'h77);
        for (int k = 0; k < 100; k++) begin
            if (done) break;
            tick(1);
        end
        tick(3);
        chk("R12 no stop stays busy", busy, 1);
        chk("R12 no stop done", done, 1);
        chk("R12 no stop ops", log_n, 2);
        hwrite(8'h78);
        chk("R10 access error", e_acc, 1);
        chk("R10 residual zero", be, 0);

        // R11 nack on send
        do_reset();
        nack_send = 1;
        send_cmd(mk(1, 1, 0, 7'h0B, 16'd3));
        wait_busy(1);
        hwrite(8'h99);
        wait_busy(0);
        tick(2);
        chk("R11 nack flag", e_nack, 1);
        chk("R11 done", done, 1);
        chk("R11 stop issued", log_op[log_n - 1], 3);
        chk("R11 op count", log_n, 3);
        chk("R11 bus residual", fe, 2);

        // R5 nack on start
        do_reset();
        nack_start = 1;
        send_cmd(mk(1, 1, 0, 7'h0C, 16'd2));
        chk("R5 done cleared during start", done, 0);
        for (int k = 0; k < 100; k++) begin
            if (done) break;
            tick(1);
        end
        tick(4);
        chk("R5 nack flag", e_nack, 1);
        chk("R5 not busy", busy, 0);
        chk("R5 done", done, 1);
        chk("R5 only start", log_n, 1);

        summary();
        $finish;
    end
endmodule